// File: doc/BRIEF.md
# Mode-banked processor register file

This block holds the 32-bit integer registers of a processor that has sixteen logical registers and several privilege modes. A 5-bit mode input selects which physical copy each logical index reaches. Low registers are common to every mode. The middle group has one copy for the fast-interrupt mode and another copy for all other modes. The stack pointer and link register have a copy for each privileged mode. In total, 31 physical words are stored.

Two read ports return data combinationally, and one write port takes effect on the rising clock edge. All three ports use logical indices 0 to 15. Index 15 is the program counter and is not stored. A read of index 15 returns the value on `pc_in`. A write to index 15 is an interworking branch: it loads the instruction-set state flag from bit 0 of the written value. It also presents an aligned target with a one-cycle strobe, which the fetch logic consumes.

Top module: `banked_regfile`

## Requirements
- R1: Logical indices 0 to 7 reach one physical copy in every mode, so a value written in one mode reads back the same in any other mode.
- R2: Indices 8 to 12 have two copies: fast-interrupt mode (code 10001) uses one, and all other modes share the other.
- R3: Index 13 has a separate copy for each of fast-interrupt (10001), interrupt (10010), supervisor (10011), abort (10111), hypervisor (11010) and undefined (11011). User (10000) and system (11111) share a seventh copy.
- R4: Index 14 has a separate copy for each of fast-interrupt, interrupt, supervisor, abort and undefined. User, system and hypervisor share one copy.
- R5: A read of index 15 on either port returns `pc_in` in the same cycle, whatever the mode.
- R6: A write to index 15 sets `isa_state` to bit 0 of the written value after the clock edge. It also raises `br_valid` for exactly the one cycle that follows that edge.
- R7: The branch target is the written value with bit 0 cleared when bit 0 is 1. It is the written value with bits 1 and 0 cleared when bit 0 is 0.
- R8: If the mode is not one of the eight listed codes, then any read port addressing index 13 or 14, or an enabled write to 13 or 14, raises `mode_err` in the same cycle. That read returns 0 and that write is dropped. Indices 0 to 12 are still served, and indices 8 to 12 reach the non-fast-interrupt copy.
- R9: A write changes storage at the rising edge only. A read of the same index in the same cycle returns the old value.
- R10: A synchronous active-high reset clears every physical register, `isa_state` and `br_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 5 | Current processor mode code |
| rd_a_idx | input | 4 | Logical index of read port A |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 4 | Logical index of read port B |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical index of the write port |
| wr_data | input | 32 | Write data |
| pc_in | input | 32 | Current program counter value |
| isa_state | output | 1 | Instruction-set state flag |
| br_valid | output | 1 | Branch target strobe, one cycle |
| br_target | output | 32 | Aligned branch target |
| mode_err | output | 1 | Unrecognised mode on a banked access |

## Verification
The properties assume that `mode`, the indices and the write controls change only between clock edges and are stable at each sampling point. They also assume that reset is high at time zero. The bench drives every input on the falling edge and samples one nanosecond later, so it stays within these assumptions. The read-hold property assumes that an index and mode held across a cycle with no write addresses the same word. This is what the alias table guarantees. It is why the bench exercises illegal modes only with explicit returns to legal ones, never mid-write.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int PHYS_N = 31;
  localparam int PHYS_W = $clog2(PHYS_N);
  localparam int SLOT_W = 3;

  // base physical slots for each group
  localparam int HI_USR_BASE = 8;
  localparam int HI_FIQ_BASE = 13;
  localparam int SP_BASE     = 18;
  localparam int LR_BASE     = 25;

  typedef enum logic [4:0] {
    M_USR = 5'b10000,
    M_FIQ = 5'b10001,
    M_IRQ = 5'b10010,
    M_SVC = 5'b10011,
    M_ABT = 5'b10111,
    M_HYP = 5'b11010,
    M_UND = 5'b11011,
    M_SYS = 5'b11111
  } cpu_mode_e;

  typedef struct packed {
    logic              legal;
    logic              fiq;
    logic [SLOT_W-1:0] sp_slot;
    logic [SLOT_W-1:0] lr_slot;
  } mode_info_t;
endpackage

// File: rtl/bankreg_mode_dec.sv
module bankreg_mode_dec
  import bankreg_pkg::*;
(
  input  logic [4:0] mode,
  output mode_info_t info
);
  always_comb begin
    info = '0;
    info.legal = 1'b1;
    unique case (mode)
      M_USR, M_SYS: begin info.sp_slot = 3'd0; info.lr_slot = 3'd0; end
      M_FIQ: begin info.fiq = 1'b1; info.sp_slot = 3'd1; info.lr_slot = 3'd1; end
      M_IRQ: begin info.sp_slot = 3'd2; info.lr_slot = 3'd2; end
      M_SVC: begin info.sp_slot = 3'd3; info.lr_slot = 3'd3; end
      M_ABT: begin info.sp_slot = 3'd4; info.lr_slot = 3'd4; end
      M_HYP: begin info.sp_slot = 3'd5; info.lr_slot = 3'd0; end
      M_UND: begin info.sp_slot = 3'd6; info.lr_slot = 3'd5; end
      default: info.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/bankreg_alias.sv
module bankreg_alias
  import bankreg_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0]  idx,
  input  mode_info_t        info,
  output logic [PHYS_W-1:0] phys,
  output logic              is_pc,
  output logic              bad
);
  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(15);
  localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(13);
  localparam logic [IDX_W-1:0] LR_IDX = IDX_W'(14);

  logic banked_hi;

  always_comb begin
    is_pc     = (idx == PC_IDX);
    banked_hi = (idx == SP_IDX) || (idx == LR_IDX);
    bad       = banked_hi && !info.legal;
    phys      = '0;
    if (idx < IDX_W'(8))
      phys = PHYS_W'(idx);
    else if (idx < SP_IDX)
      phys = info.fiq ? PHYS_W'(idx) + PHYS_W'(HI_FIQ_BASE - 8)
                      : PHYS_W'(idx);
    else if (idx == SP_IDX)
      phys = PHYS_W'(SP_BASE) + PHYS_W'(info.sp_slot);
    else if (idx == LR_IDX)
      phys = PHYS_W'(LR_BASE) + PHYS_W'(info.lr_slot);
  end
endmodule

// File: rtl/bankreg_store.sv
module bankreg_store #(
  parameter int DEPTH  = 31,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = (int'(raddr_a) < DEPTH) ? mem[raddr_a] : '0;
  assign rdata_b = (int'(raddr_b) < DEPTH) ? mem[raddr_b] : '0;
endmodule

// File: rtl/bankreg_branch.sv
module bankreg_branch #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DATA_W-1:0] value,
  output logic              isa_state,
  output logic              br_valid,
  output logic [DATA_W-1:0] br_target
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    mask = '1;
    mask[0] = 1'b0;
    if (!value[0]) mask[1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isa_state <= 1'b0;
      br_valid  <= 1'b0;
      br_target <= '0;
    end else begin
      br_valid <= take;
      if (take) begin
        isa_state <= value[0];
        br_target <= value & mask;
      end
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        mode,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] pc_in,
  output logic              isa_state,
  output logic              br_valid,
  output logic [DATA_W-1:0] br_target,
  output logic              mode_err
);
  localparam int NPORT = 3;  // 0: read A, 1: read B, 2: write

  mode_info_t        info;
  logic [IDX_W-1:0]  idx   [NPORT];
  logic [PHYS_W-1:0] phys  [NPORT];
  logic              is_pc [NPORT];
  logic              bad   [NPORT];
  logic [DATA_W-1:0] mem_a, mem_b;
  logic              store_we, branch_take;

  bankreg_mode_dec u_dec (.mode(mode), .info(info));

  assign idx[0] = rd_a_idx;
  assign idx[1] = rd_b_idx;
  assign idx[2] = wr_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_alias
    bankreg_alias #(.IDX_W(IDX_W)) u_alias (
      .idx  (idx[p]),
      .info (info),
      .phys (phys[p]),
      .is_pc(is_pc[p]),
      .bad  (bad[p])
    );
  end

  assign store_we    = wr_en && !is_pc[2] && !bad[2];
  assign branch_take = wr_en && is_pc[2];

  bankreg_store #(.DEPTH(PHYS_N), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we     (store_we),
    .waddr  (phys[2]),
    .wdata  (wr_data),
    .raddr_a(phys[0]),
    .rdata_a(mem_a),
    .raddr_b(phys[1]),
    .rdata_b(mem_b)
  );

  bankreg_branch #(.DATA_W(DATA_W)) u_branch (
    .clk      (clk),
    .rst      (rst),
    .take     (branch_take),
    .value    (wr_data),
    .isa_state(isa_state),
    .br_valid (br_valid),
    .br_target(br_target)
  );

  always_comb begin
    rd_a_data = is_pc[0] ? pc_in : (bad[0] ? '0 : mem_a);
    rd_b_data = is_pc[1] ? pc_in : (bad[1] ? '0 : mem_b);
    mode_err  = bad[0] || bad[1] || (wr_en && bad[2]);
  end
endmodule

// File: rtl/bankreg_checker.sv
module bankreg_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        mode,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [IDX_W-1:0]  rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] pc_in,
  input logic              isa_state,
  input logic              br_valid,
  input logic [DATA_W-1:0] br_target,
  input logic              mode_err
);
  logic mode_ok, a_banked, pc_wr;
  assign mode_ok  = (mode == 5'b10000) || (mode == 5'b10001) || (mode == 5'b10010) ||
                    (mode == 5'b10011) || (mode == 5'b10111) || (mode == 5'b11010) ||
                    (mode == 5'b11011) || (mode == 5'b11111);
  assign a_banked = (rd_a_idx == IDX_W'(13)) || (rd_a_idx == IDX_W'(14));
  assign pc_wr    = wr_en && (wr_idx == IDX_W'(15));

  p_pc_read_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == IDX_W'(15)) |-> (rd_b_data == pc_in));

  p_branch_take_r6: assert property (@(posedge clk) disable iff (rst)
    pc_wr |=> (br_valid && (isa_state == $past(wr_data[0]))));

  p_branch_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    !pc_wr |=> !br_valid);

  p_align_r7: assert property (@(posedge clk) disable iff (rst)
    br_valid |-> (!br_target[0] && (isa_state || !br_target[1])));

  p_bad_read_r8: assert property (@(posedge clk) disable iff (rst)
    (a_banked && !mode_ok) |-> (mode_err && (rd_a_data == '0)));

  p_ok_mode_r8: assert property (@(posedge clk) disable iff (rst)
    mode_ok |-> !mode_err);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (!$stable(rd_a_idx) || !$stable(mode) ||
                (rd_a_idx == IDX_W'(15)) || $stable(rd_a_data)));

  p_reset_r10: assert property (@(posedge clk)
    $past(rst) |-> (!br_valid && !isa_state &&
                    ((rd_a_idx == IDX_W'(15)) || (rd_a_data == '0))));
endmodule

bind banked_regfile bankreg_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .pc_in(pc_in),
  .isa_state(isa_state), .br_valid(br_valid), .br_target(br_target),
  .mode_err(mode_err)
);

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
module banked_regfile_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  mode = 5'b10000;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pc_in = '0, br_target;
  logic        wr_en = 1'b0, isa_state, br_valid, mode_err;

  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010, SVC = 5'b10011,
                         ABT = 5'b10111, HYP = 5'b11010, UND = 5'b11011, SYS = 5'b11111;

  always #2.5 clk = ~clk;

  banked_regfile uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] m, logic [3:0] i, logic [31:0] d);
    @(negedge clk);
    mode = m; wr_idx = i; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] m, logic [3:0] i, output logic [31:0] d);
    @(negedge clk);
    mode = m; rd_a_idx = i;
    #1 d = rd_a_data;
  endtask

  function automatic int sp_copy(logic [4:0] m);
    case (m)
      FIQ: return 1; IRQ: return 2; SVC: return 3;
      ABT: return 4; HYP: return 5; UND: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic int lr_copy(logic [4:0] m);
    case (m)
      FIQ: return 1; IRQ: return 2; SVC: return 3;
      ABT: return 4; UND: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 15; i++) begin
      rd(USR, 4'(i), d); chk("R10 reg cleared", d, 0);
    end
    rd(FIQ, 4'd13, d); chk("R10 fiq sp cleared", d, 0);
    chk("R10 isa_state", {31'b0, isa_state}, 0);
    chk("R10 br_valid", {31'b0, br_valid}, 0);
  endtask

  task automatic t_shared();
    logic [31:0] d;
    wr(SVC, 4'd3, 32'hA5A5_0003);
    wr(FIQ, 4'd7, 32'h0707_0707);
    rd(USR, 4'd3, d); chk("R1 r3 user", d, 32'hA5A5_0003);
    rd(FIQ, 4'd3, d); chk("R1 r3 fiq", d, 32'hA5A5_0003);
    rd(UND, 4'd7, d); chk("R1 r7 und", d, 32'h0707_0707);
  endtask

  task automatic t_fiq_bank();
    logic [31:0] d;
    wr(USR, 4'd10, 32'h1111_000A);
    wr(FIQ, 4'd10, 32'h2222_000A);
    wr(IRQ, 4'd12, 32'h3333_000C);
    rd(USR, 4'd10, d); chk("R2 r10 user", d, 32'h1111_000A);
    rd(ABT, 4'd10, d); chk("R2 r10 abt shares user", d, 32'h1111_000A);
    rd(FIQ, 4'd10, d); chk("R2 r10 fiq", d, 32'h2222_000A);
    rd(SYS, 4'd12, d); chk("R2 r12 sys sees irq write", d, 32'h3333_000C);
    rd(FIQ, 4'd12, d); chk("R2 r12 fiq separate", d, 0);
  endtask

  task automatic t_banked(logic [3:0] idx, string req);
    logic [4:0]  ml [8] = '{USR, FIQ, IRQ, SVC, ABT, HYP, UND, SYS};
    logic [31:0] copy [7];
    logic [31:0] d;
    for (int c = 0; c < 7; c++) copy[c] = 0;
    for (int k = 0; k < 8; k++) begin
      logic [31:0] v = {idx, 20'h0, 8'(k + 1)};
      int c = (idx == 4'd13) ? sp_copy(ml[k]) : lr_copy(ml[k]);
      wr(ml[k], idx, v);
      copy[c] = v;
    end
    for (int k = 0; k < 8; k++) begin
      int c = (idx == 4'd13) ? sp_copy(ml[k]) : lr_copy(ml[k]);
      rd(ml[k], idx, d); chk(req, d, copy[c]);
    end
  endtask

  task automatic t_pc();
    @(negedge clk);
    mode = IRQ; rd_a_idx = 4'd15; rd_b_idx = 4'd15; pc_in = 32'h0000_8004;
    #1 chk("R5 pc port a", rd_a_data, 32'h0000_8004);
    chk("R5 pc port b", rd_b_data, 32'h0000_8004);
    @(negedge clk);
    mode = 5'b00000; pc_in = 32'hDEAD_BEE0;
    #1 chk("R5 pc any mode", rd_b_data, 32'hDEAD_BEE0);
    rd_b_idx = 4'd0;
  endtask

  task automatic t_branch(logic [31:0] v, logic [31:0] tgt);
    wr(SVC, 4'd15, v);
    #1 chk("R6 br_valid after edge", {31'b0, br_valid}, 1);
    chk("R6 isa_state", {31'b0, isa_state}, {31'b0, v[0]});
    chk("R7 target", br_target, tgt);
    @(negedge clk); #1;
    chk("R6 br_valid one cycle", {31'b0, br_valid}, 0);
    chk("R6 isa_state holds", {31'b0, isa_state}, {31'b0, v[0]});
  endtask

  task automatic t_badmode();
    logic [31:0] d;
    @(negedge clk);
    mode = 5'b00000; rd_a_idx = 4'd2; rd_b_idx = 4'd2;
    wr_idx = 4'd13; wr_data = 32'hBAD0_0013; wr_en = 1'b1;
    #1 chk("R8 err on write", {31'b0, mode_err}, 1);
    @(negedge clk);
    wr_en = 1'b0; rd_a_idx = 4'd14;
    #1 chk("R8 err on read", {31'b0, mode_err}, 1);
    chk("R8 read zero", rd_a_data, 0);
    rd_a_idx = 4'd10;
    #1 chk("R8 no err low idx", {31'b0, mode_err}, 0);
    chk("R8 r10 reaches user copy", rd_a_data, 32'h1111_000A);
    rd(USR, 4'd13, d); chk("R8 write dropped usr sp", d, 32'hD000_0008);
    chk("R8 legal mode no err", {31'b0, mode_err}, 0);
    rd(HYP, 4'd13, d); chk("R8 write dropped hyp sp", d, 32'hD000_0006);
  endtask

  task automatic t_no_bypass();
    @(negedge clk);
    mode = USR; rd_a_idx = 4'd5; wr_idx = 4'd5; wr_data = 32'h5555_AAAA; wr_en = 1'b1;
    #1 chk("R9 old value same cycle", rd_a_data, 0);
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R9 new value after edge", rd_a_data, 32'h5555_AAAA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_shared();
    t_fiq_bank();
    t_banked(4'd13, "R3 sp bank");
    t_banked(4'd14, "R4 lr bank");
    t_pc();
    t_branch(32'h0000_1235, 32'h0000_1234);
    t_branch(32'h0000_1236, 32'h0000_1234);
    t_branch(32'hFFFF_FFFF, 32'hFFFF_FFFE);
    t_branch(32'h0000_2003, 32'h0000_2002);
    t_badmode();
    t_no_bypass();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule